// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves one byte at a time over a three-wire synchronous link. It shifts a byte out on `sout` while it shifts a byte in from `sin`. Both happen on the same shift clock. That clock is either produced here from the system clock, from the system clock halved, or from a timer overflow pulse (master), or it is taken from an external pin (slave). A small CPU drives the block through nibble-wide registers on a simple read/write bus.

A transfer is set up in three steps. First, software accesses the data register (a write or a read), which arms the sequencer. It then writes the start bit, and the state machine moves IDLE -> ARMED -> SHIFT. After the eighth sampling edge the machine goes SHIFT -> IDLE and raises the completion flag. Data accesses while in ARMED keep it in ARMED. The completion flag clears when it is read. The interrupt line is the flag qualified by a mask bit.

Register map on `bus_addr`:
- 0 = configuration: bits [1:0] clock select, bit 2 bit order, bit 3 interrupt mask.
- 1 = command/status: write bit 0 = start; read bit 1 = busy, bit 0 = 0.
- 2 = data bits 3:0.
- 3 = data bits 7:4.
- 4 = completion flag in bit 0.

Top module: `sync_serial_ctl`

## Requirements
- R1: Clock select bits [1:0] of register 0 pick the shift clock: 11 toggles the internal clock every system cycle, 10 toggles it every second cycle, 01 toggles it on each `timer_ovf` pulse, and 00 uses `sclk_in` (slave). The field resets to 00. In master modes `sclk_out` idles high, and a byte takes 16 cycles (mode 11) or 32 cycles (mode 10) of busy time.
- R2: Bit 2 of register 0 set to 1 sends and receives LSB first; 0 means MSB first. It resets to 0.
- R3: Writing 1 to bit 0 of register 1 starts a transfer. Writing 0 does nothing, and that bit always reads 0.
- R4: A start is ignored unless the data register (address 2 or 3) was written or read since the last transfer ended.
- R5: Bit 1 of register 1 reads 1 while a transfer is running and 0 otherwise. It reads 0 after reset.
- R6: Address 2 holds data bits 3:0 and address 3 holds bits 7:4. The written byte is sent on `sout`, and after the transfer the same addresses return the byte received on `sin`.
- R7: `sout` changes after a falling shift-clock edge, and `sin` is sampled at a rising edge. In slave mode `sclk_in` passes through a two-stage synchronizer before its edges are used.
- R8: Bit 0 of address 4 becomes 1 when a transfer ends, whatever the mask. A read of address 4 clears it. Writes to address 4 have no effect.
- R9: `irq` is high only while both the completion flag and mask bit 3 of register 0 are 1. The mask resets to 0.
- R10: A transfer stops after exactly 8 rising shift edges, with no further shift-clock edges, and disarms the sequencer. A second start with no new data access does nothing.
- R11: Writes to the data addresses while a transfer runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_wdata | input | 4 | Write data nibble |
| bus_rdata | output | 4 | Read data nibble for `bus_addr` |
| timer_ovf | input | 1 | One-cycle timer overflow pulse |
| sclk_in | input | 1 | External shift clock (slave) |
| sin | input | 1 | Serial data in |
| sclk_out | output | 1 | Generated shift clock (master) |
| sclk_oe | output | 1 | High in master modes |
| sout | output | 1 | Serial data out |
| irq | output | 1 | Masked completion request |

## Verification
The hardest condition to reach from the ports is the rejected start. The machine must be in IDLE after a finished transfer with no intervening data access. The stimulus therefore issues a start straight after the busy bit drops, before any data read, and confirms that busy stays low and `sclk_out` stays high.

A data write in the middle of a shift is also awkward to reach. The bench issues that write while busy is still high in the halved-clock mode, then checks that the received byte reads back intact. In every clock mode, a serial peer in the bench follows the shift clock and feeds `sin`.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
    typedef enum logic [1:0] {
        CS_SLAVE = 2'b00,
        CS_TIMER = 2'b01,
        CS_HALF  = 2'b10,
        CS_FULL  = 2'b11
    } clksel_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ARMED = 2'b01,
        ST_SHIFT = 2'b10
    } xfer_state_t;

    localparam int unsigned NIB_W    = 4;
    localparam int unsigned REG_CFG  = 0;
    localparam int unsigned REG_CMD  = 1;
    localparam int unsigned REG_DAT  = 2;
    localparam int unsigned REG_FLAG = 4;
endpackage

// File: rtl/ssi_clkgen.sv
module ssi_clkgen
    import ssi_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  clksel_t csel,
    input  logic    run,
    input  logic    timer_ovf,
    input  logic    sclk_in,
    output logic    rise,
    output logic    fall,
    output logic    sclk_out,
    output logic    sclk_oe
);
    logic [SYNC_STAGES:0] sync_q;
    logic                 div_q;
    logic                 sclk_q;
    logic                 tick;
    logic                 master;
    logic                 s_cur;
    logic                 s_prev;

    assign master = (csel != CS_SLAVE);

    // external clock synchronizer plus one stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], sclk_in};
    end

    assign s_cur  = sync_q[SYNC_STAGES-1];
    assign s_prev = sync_q[SYNC_STAGES];

    // halved-clock divider, restarted for every transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    div_q <= 1'b0;
        else if (!run) div_q <= 1'b0;
        else           div_q <= ~div_q;
    end

    always_comb begin
        unique case (csel)
            CS_FULL:  tick = 1'b1;
            CS_HALF:  tick = div_q;
            CS_TIMER: tick = timer_ovf;
            CS_SLAVE: tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                sclk_q <= 1'b1;
        else if (!run || !master)  sclk_q <= 1'b1;
        else if (tick)             sclk_q <= ~sclk_q;
    end

    always_comb begin
        if (master) begin
            rise = run & tick & ~sclk_q;
            fall = run & tick & sclk_q;
        end else begin
            rise = run & s_cur & ~s_prev;
            fall = run & ~s_cur & s_prev;
        end
    end

    assign sclk_out = sclk_q;
    assign sclk_oe  = master;
endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter
    import ssi_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned NIBS  = DATA_W / NIB_W,
    localparam int unsigned CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lsb_first,
    input  logic              load_start,
    input  logic              rise,
    input  logic              fall,
    input  logic              sin,
    input  logic [NIBS-1:0]   nib_we,
    input  logic [NIB_W-1:0]  nib_wdata,
    output logic [DATA_W-1:0] data,
    output logic              sout,
    output logic              done,
    output logic [CNT_W-1:0]  bit_cnt
);
    logic [DATA_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              out_q;
    logic              head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (rise) begin
            if (lsb_first) sr_q <= {sin, sr_q[DATA_W-1:1]};
            else           sr_q <= {sr_q[DATA_W-2:0], sin};
        end else begin
            for (int n = 0; n < NIBS; n++) begin
                if (nib_we[n]) sr_q[n*NIB_W +: NIB_W] <= nib_wdata;
            end
        end
    end

    assign head = lsb_first ? sr_q[0] : sr_q[DATA_W-1];

    // output bit moves only on the falling edge (or at start)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  out_q <= 1'b1;
        else if (load_start || fall) out_q <= head;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load_start) cnt_q <= '0;
        else if (rise)       cnt_q <= cnt_q + 1'b1;
    end

    assign done    = rise && (cnt_q == CNT_W'(DATA_W - 1));
    assign data    = sr_q;
    assign sout    = out_q;
    assign bit_cnt = cnt_q;
endmodule

// File: rtl/ssi_seq.sv
module ssi_seq
    import ssi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic data_acc,
    input  logic trig_wr,
    input  logic done,
    input  logic flag_rd,
    output logic run,
    output logic armed,
    output logic start,
    output logic flag
);
    xfer_state_t state_q, state_d;
    logic        flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (data_acc) state_d = ST_ARMED;
            ST_ARMED: if (trig_wr)  state_d = ST_SHIFT;
            ST_SHIFT: if (done)     state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run   = (state_q == ST_SHIFT);
        armed = (state_q == ST_ARMED);
        start = (state_q == ST_ARMED) && trig_wr;
    end

    // completion flag: set wins over the clearing read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (done)    flag_q <= 1'b1;
        else if (flag_rd) flag_q <= 1'b0;
    end

    assign flag = flag_q;
endmodule

// File: rtl/sync_serial_ctl.sv
module sync_serial_ctl
    import ssi_pkg::*;
#(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_wdata,
    output logic [3:0]        bus_rdata,
    input  logic              timer_ovf,
    input  logic              sclk_in,
    input  logic              sin,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sout,
    output logic              irq
);
    localparam int unsigned NIBS  = DATA_W / NIB_W;
    localparam int unsigned CNT_W = $clog2(DATA_W);

    clksel_t           csel_q;
    logic              lsb_q;
    logic              mask_q;
    logic              run_st;
    logic              armed;
    logic              start;
    logic              flag_q;
    logic              rise;
    logic              fall;
    logic              done;
    logic [DATA_W-1:0] data;
    logic [CNT_W-1:0]  bit_cnt;
    logic [NIBS-1:0]   nib_hit;
    logic [NIBS-1:0]   nib_we;
    logic              sel_cfg;
    logic              sel_cmd;
    logic              sel_flag;
    logic              data_acc;
    logic              trig_wr;
    logic              flag_rd;
    logic              master;

    assign sel_cfg  = (bus_addr == ADDR_W'(REG_CFG));
    assign sel_cmd  = (bus_addr == ADDR_W'(REG_CMD));
    assign sel_flag = (bus_addr == ADDR_W'(REG_FLAG));

    generate
        for (genvar n = 0; n < NIBS; n++) begin : g_nib
            assign nib_hit[n] = (bus_addr == ADDR_W'(REG_DAT + n));
            assign nib_we[n]  = nib_hit[n] && bus_wr && !run_st;
        end
    endgenerate

    assign data_acc = (|nib_hit) && (bus_wr || bus_rd) && !run_st;
    assign trig_wr  = sel_cmd && bus_wr && bus_wdata[0];
    assign flag_rd  = sel_flag && bus_rd;
    assign master   = (csel_q != CS_SLAVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csel_q <= CS_SLAVE;
            lsb_q  <= 1'b0;
            mask_q <= 1'b0;
        end else if (sel_cfg && bus_wr) begin
            csel_q <= clksel_t'(bus_wdata[1:0]);
            lsb_q  <= bus_wdata[2];
            mask_q <= bus_wdata[3];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_cfg)       bus_rdata = {mask_q, lsb_q, csel_q};
        else if (sel_cmd)  bus_rdata = {2'b00, run_st, 1'b0};
        else if (sel_flag) bus_rdata = {3'b000, flag_q};
        else begin
            for (int n = 0; n < NIBS; n++) begin
                if (nib_hit[n]) bus_rdata = data[n*NIB_W +: NIB_W];
            end
        end
    end

    ssi_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_acc (data_acc),
        .trig_wr  (trig_wr),
        .done     (done),
        .flag_rd  (flag_rd),
        .run      (run_st),
        .armed    (armed),
        .start    (start),
        .flag     (flag_q)
    );

    ssi_clkgen #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .csel      (csel_q),
        .run       (run_st),
        .timer_ovf (timer_ovf),
        .sclk_in   (sclk_in),
        .rise      (rise),
        .fall      (fall),
        .sclk_out  (sclk_out),
        .sclk_oe   (sclk_oe)
    );

    ssi_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .lsb_first  (lsb_q),
        .load_start (start),
        .rise       (rise),
        .fall       (fall),
        .sin        (sin),
        .nib_we     (nib_we),
        .nib_wdata  (bus_wdata),
        .data       (data),
        .sout       (sout),
        .done       (done),
        .bit_cnt    (bit_cnt)
    );

    assign irq = flag_q & mask_q;
endmodule

// File: rtl/ssi_chk.sv
module ssi_chk #(
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_st,
    input logic             armed,
    input logic             flag_q,
    input logic             flag_rd,
    input logic             done,
    input logic             master,
    input logic             sclk_out,
    input logic [CNT_W-1:0] bit_cnt
);
    AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_st) |-> $past(armed)); // R4

    AST_END_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_st) |-> flag_q); // R8

    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_rd) && !$past(done)) |-> !flag_q); // R8

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !run_st) |-> sclk_out); // R1

    AST_COUNT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_st) |-> (bit_cnt == '0)); // R10
endmodule

bind sync_serial_ctl ssi_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_st   (run_st),
    .armed    (armed),
    .flag_q   (flag_q),
    .flag_rd  (flag_rd),
    .done     (done),
    .master   (master),
    .sclk_out (sclk_out),
    .bit_cnt  (bit_cnt)
);

// File: tb/sync_serial_ctl_tb.sv
module sync_serial_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       timer_ovf = 1'b0;
    logic       sclk_in = 1'b1;
    logic       sin_q = 1'b0;
    logic       sclk_out, sclk_oe, sout, irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // serial peer controls (driven by main) and state (driven by peer)
    logic [7:0] peer_rx = '0;
    bit         peer_lsb = 0;
    bit         peer_slave = 0;
    bit         peer_clr = 0;
    bit         tmr_en = 0;
    logic [7:0] cap = '0;
    int         nbits = 0;
    logic       prev_line = 1'b1;
    int         tmr_cnt = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    sync_serial_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .timer_ovf(timer_ovf), .sclk_in(sclk_in), .sin(sin_q),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sout(sout), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic pick(input logic [7:0] b, input bit lsb, input int i);
        return lsb ? b[i] : b[7-i];
    endfunction

    // timer overflow source: one pulse every fifth cycle
    always @(negedge clk) begin
        if (tmr_en) begin
            tmr_cnt   <= (tmr_cnt == 4) ? 0 : tmr_cnt + 1;
            timer_ovf <= (tmr_cnt == 4);
        end else begin
            timer_ovf <= 1'b0;
        end
    end

    // monitor / serial peer: samples sout on rising line, feeds sin after falling line
    always @(negedge clk) begin
        logic line;
        line = peer_slave ? sclk_in : sclk_out;
        if (peer_clr) begin
            nbits = 0;
            cap   = '0;
            sin_q <= pick(peer_rx, peer_lsb, 0);
        end else if (line && !prev_line) begin
            cap = peer_lsb ? {sout, cap[7:1]} : {cap[6:0], sout};
            nbits++;
            if (nbits == 8) begin
                if (exp_q.size() == 0) check(0, "R6 R7 unexpected byte", cap, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(cap == e, "R6 R7 sout byte", cap, e);
                end
            end
        end else if (!line && prev_line && nbits < 8) begin
            sin_q <= pick(peer_rx, peer_lsb, nbits);
        end
        prev_line = line;
    end

    task automatic bus_write(input logic [2:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [3:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic slave_drive();
        for (int k = 0; k < 8; k++) begin
            repeat (6) @(negedge clk);
            sclk_in = 1'b0;
            repeat (6) @(negedge clk);
            sclk_in = 1'b1;
        end
    endtask

    // driver: sets up one transfer, pushes the expected outgoing byte
    task automatic do_xfer(input logic [1:0] cs, input bit lsb, input bit msk,
                           input logic [7:0] tx, input logic [7:0] rx,
                           input int exp_cyc, input bit midwr);
        logic [3:0] lo, hi, f;
        int cyc;
        bus_write(3'd0, {msk, lsb, cs});
        peer_rx = rx; peer_lsb = lsb; peer_slave = (cs == 2'b00);
        peer_clr = 1;
        @(negedge clk); @(negedge clk);
        peer_clr = 0;
        exp_q.push_back(tx);
        bus_write(3'd2, tx[3:0]);
        bus_write(3'd3, tx[7:4]);
        bus_write(3'd1, 4'b0001);
        if (cs == 2'b00) fork slave_drive(); join_none
        bus_addr = 3'd1;
        #1;
        check(bus_rdata == 4'b0010, "R3 R5 busy set, start bit reads 0", bus_rdata, 4'b0010);
        if (midwr) begin
            bus_write(3'd2, ~tx[3:0]);
            bus_write(3'd3, ~tx[7:4]);
            bus_addr = 3'd1;
            #1;
        end
        cyc = 0;
        while (bus_rdata[1] && cyc < 4000) begin
            cyc++;
            @(negedge clk);
            #1;
        end
        check(cyc < 4000, "R10 transfer ends", cyc, 0);
        if (exp_cyc != 0) check(cyc == exp_cyc, "R1 busy duration", cyc, exp_cyc);
        repeat (3) @(negedge clk);
        check(irq == msk, "R9 irq follows mask", irq, msk);
        // restart with no data access must be rejected
        bus_write(3'd1, 4'b0001);
        bus_addr = 3'd1;
        repeat (10) @(negedge clk);
        #1;
        check(bus_rdata[1] == 1'b0, "R10 second start ignored", bus_rdata, 0);
        if (cs != 2'b00) check(sclk_out == 1'b1, "R10 no extra shift clock", sclk_out, 1);
        check(nbits == 8, "R10 exactly 8 bits", nbits, 8);
        bus_read(3'd2, lo);
        bus_read(3'd3, hi);
        check({hi, lo} == rx, "R2 R6 R11 received byte", {hi, lo}, rx);
        bus_read(3'd4, f);
        check(f == 4'd1, "R8 flag set after transfer", f, 1);
        bus_read(3'd4, f);
        check(f == 4'd0, "R8 flag cleared by read", f, 0);
        #1;
        check(irq == 1'b0, "R9 irq low after clear", irq, 0);
    endtask

    initial begin
        logic [3:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_read(3'd0, d);
        check(d == 4'h0, "R1 R2 R9 config reset", d, 0);
        bus_read(3'd1, d);
        check(d == 4'h0, "R5 idle after reset", d, 0);
        bus_read(3'd4, d);
        check(d == 4'h0, "R8 flag reset", d, 0);
        check(irq == 1'b0, "R9 irq reset", irq, 0);
        // start before any data access
        bus_write(3'd1, 4'b0001);
        bus_addr = 3'd1;
        repeat (4) @(negedge clk);
        #1;
        check(bus_rdata[1] == 1'b0, "R4 unarmed start ignored", bus_rdata, 0);
        // writes to the flag are ignored
        bus_write(3'd4, 4'b0001);
        bus_read(3'd4, d);
        check(d == 4'h0, "R8 flag write ignored", d, 0);

        do_xfer(2'b11, 1'b0, 1'b0, 8'hA5, 8'h3C, 16, 1'b0);
        do_xfer(2'b10, 1'b1, 1'b1, 8'h81, 8'h6E, 32, 1'b0);
        do_xfer(2'b10, 1'b0, 1'b0, 8'h5A, 8'hC3, 0, 1'b1);
        tmr_en = 1;
        do_xfer(2'b01, 1'b1, 1'b0, 8'h37, 8'hE4, 0, 1'b0);
        tmr_en = 0;
        do_xfer(2'b00, 1'b0, 1'b1, 8'h92, 8'h1F, 0, 1'b0);
        do_xfer(2'b00, 1'b1, 1'b0, 8'h4B, 8'hD2, 0, 1'b0);
        check(exp_q.size() == 0, "R6 all bytes seen", exp_q.size(), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule